// File: doc/BRIEF.md
# GPIO Bank with Per-Pin Interrupts

This block is one bank of general-purpose pins behind a small word-addressed register port. Software sets each pin's direction and output value, and reads back the level the pin actually carries after a two-stage synchronizer. The readback works whether the pin is an input or an output.

Every pin can also raise an interrupt. Each pin has its own enable bit and its own sense bit, which picks level or edge. A third bit, the polarity, picks high/rising or low/falling. A level interrupt follows the synchronized input. An edge is caught in a sticky flag, and software clears that flag by writing a one to the matching bit of the end-of-interrupt register. All enabled pending pins are reported in a status word and combine into one bank interrupt line.

Register map (byte addresses, 32-bit data, all registers reset to zero):

| Address | Register |
|---|---|
| 0x00 | output data |
| 0x04 | direction |
| 0x30 | interrupt enable |
| 0x38 | sense |
| 0x3C | polarity |
| 0x40 | status |
| 0x4C | end-of-interrupt |
| 0x50 | pin level |

Top module: `pin_bank_irq`

## Requirements
- R1: After reset, every register reads 0, `pin_oe` and `pin_out` are 0 and `irq_out` is 0.
- R2: Direction bit n set to 1 (address 0x04) drives `pin_oe[n]` high. `pin_out` always equals the output data register (address 0x00) in the cycle after the write.
- R3: A read of address 0x50 returns `pin_in` delayed by two clock edges, whatever the direction. Writes to 0x50 have no effect.
- R4: With sense bit 0 (level) and the pin enabled, the pin is pending exactly while its synchronized input equals the polarity bit (1 = high, 0 = low).
- R5: With sense bit 1 (edge), a synchronized rising edge (polarity 1) or falling edge (polarity 0) sets a sticky flag. The flag stays set after the input returns.
- R6: Writing 1 to bit n of address 0x4C clears the edge flag of pin n. A 0 bit leaves it unchanged, and 0x4C reads as 0.
- R7: Writes to 0x4C do not change the pending state of a level-sensitive pin.
- R8: A disabled pin (enable bit 0 at 0x30) is never reported. An edge that occurs while the pin is disabled is not latched.
- R9: Address 0x40 returns the enabled pending pins, and `irq_out` is 1 exactly when that word is nonzero.
- R10: If an edge event and an end-of-interrupt write for the same pin fall in the same cycle, the pin stays pending.
- R11: Registers 0x00, 0x04, 0x30, 0x38 and 0x3C read back the last value written. Any unmapped address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| bus_wr | input | 1 | write strobe, one cycle per write |
| bus_addr | input | 8 | byte address of the access |
| bus_wdata | input | 32 | write data |
| bus_rdata | output | 32 | read data for `bus_addr`, combinational |
| pin_in | input | 32 | external pin levels |
| pin_out | output | 32 | output values to the pads |
| pin_oe | output | 32 | per-pin output enable |
| irq_out | output | 1 | bank interrupt |

## Verification
Two events can land on the same edge flag in one cycle: an edge detected by the synchronizer and an end-of-interrupt write that clears the flag. The bench first leaves a rising-edge pin pending and lowers its input. It then raises the input again and times the clearing write to land on the clock edge where the synchronized sample first differs from the previous one. The flag must still be set afterward. A plain clearing write with no edge present must then empty the flag, which shows that the earlier result came from the priority rule and not from a write that had no effect.

// File: rtl/pin_bank_pkg.sv
package pin_bank_pkg;
  localparam int BUS_W  = 32;
  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] A_DOUT  = 8'h00;
  localparam logic [ADDR_W-1:0] A_DIR   = 8'h04;
  localparam logic [ADDR_W-1:0] A_EN    = 8'h30;
  localparam logic [ADDR_W-1:0] A_SENSE = 8'h38;
  localparam logic [ADDR_W-1:0] A_POL   = 8'h3C;
  localparam logic [ADDR_W-1:0] A_STAT  = 8'h40;
  localparam logic [ADDR_W-1:0] A_EOI   = 8'h4C;
  localparam logic [ADDR_W-1:0] A_LEVEL = 8'h50;

  // edge of the selected direction between previous and current sample
  function automatic logic edge_hit(input logic cur, input logic prev, input logic pol);
    return pol ? (cur & ~prev) : (~cur & prev);
  endfunction

  // input currently at the active level
  function automatic logic level_hit(input logic cur, input logic pol);
    return ~(cur ^ pol);
  endfunction
endpackage

// File: rtl/pin_bank_sync.sv
module pin_bank_sync #(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] raw,
  output logic [NPINS-1:0] cur,
  output logic [NPINS-1:0] prev
);
  logic [NPINS-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      cur    <= '0;
      prev   <= '0;
    end else begin
      stage1 <= raw;
      cur    <= stage1;
      prev   <= cur;
    end
  end
endmodule

// File: rtl/pin_bank_regs.sv
module pin_bank_regs
  import pin_bank_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0]  wdata,
  input  logic [NPINS-1:0]  level,
  input  logic [NPINS-1:0]  status,
  output logic [NPINS-1:0]  dout_q,
  output logic [NPINS-1:0]  dir_q,
  output logic [NPINS-1:0]  en_q,
  output logic [NPINS-1:0]  sense_q,
  output logic [NPINS-1:0]  pol_q,
  output logic [NPINS-1:0]  eoi_clr,
  output logic [BUS_W-1:0]  rdata
);
  logic [NPINS-1:0] wbits;
  assign wbits   = wdata[NPINS-1:0];
  assign eoi_clr = (wr && addr == A_EOI) ? wbits : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q  <= '0;
      dir_q   <= '0;
      en_q    <= '0;
      sense_q <= '0;
      pol_q   <= '0;
    end else if (wr) begin
      case (addr)
        A_DOUT:  dout_q  <= wbits;
        A_DIR:   dir_q   <= wbits;
        A_EN:    en_q    <= wbits;
        A_SENSE: sense_q <= wbits;
        A_POL:   pol_q   <= wbits;
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_DOUT:  rdata[NPINS-1:0] = dout_q;
      A_DIR:   rdata[NPINS-1:0] = dir_q;
      A_EN:    rdata[NPINS-1:0] = en_q;
      A_SENSE: rdata[NPINS-1:0] = sense_q;
      A_POL:   rdata[NPINS-1:0] = pol_q;
      A_STAT:  rdata[NPINS-1:0] = status;
      A_LEVEL: rdata[NPINS-1:0] = level;
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/pin_bank_irq_core.sv
module pin_bank_irq_core
  import pin_bank_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] cur,
  input  logic [NPINS-1:0] prev,
  input  logic [NPINS-1:0] en_q,
  input  logic [NPINS-1:0] sense_q,
  input  logic [NPINS-1:0] pol_q,
  input  logic [NPINS-1:0] eoi_clr,
  output logic [NPINS-1:0] edge_evt,
  output logic [NPINS-1:0] edge_lat,
  output logic [NPINS-1:0] status
);
  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    logic lvl_act;
    assign edge_evt[i] = sense_q[i] & edge_hit(cur[i], prev[i], pol_q[i]);
    assign lvl_act     = ~sense_q[i] & level_hit(cur[i], pol_q[i]);

    // a new enabled edge takes priority over a clearing write
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       edge_lat[i] <= 1'b0;
      else if (edge_evt[i] && en_q[i])  edge_lat[i] <= 1'b1;
      else if (eoi_clr[i])              edge_lat[i] <= 1'b0;
    end

    assign status[i] = en_q[i] & (sense_q[i] ? edge_lat[i] : lvl_act);
  end
endmodule

// File: rtl/pin_bank_irq.sv
module pin_bank_irq
  import pin_bank_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe,
  output logic              irq_out
);
  logic [NPINS-1:0] cur, prev;
  logic [NPINS-1:0] dout_q, dir_q, en_q, sense_q, pol_q;
  logic [NPINS-1:0] eoi_clr, edge_evt, edge_lat, status;

  pin_bank_sync #(.NPINS(NPINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw(pin_in), .cur(cur), .prev(prev)
  );

  pin_bank_regs #(.NPINS(NPINS)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .level(cur), .status(status), .dout_q(dout_q), .dir_q(dir_q), .en_q(en_q),
    .sense_q(sense_q), .pol_q(pol_q), .eoi_clr(eoi_clr), .rdata(bus_rdata)
  );

  pin_bank_irq_core #(.NPINS(NPINS)) u_core (
    .clk(clk), .rst_n(rst_n), .cur(cur), .prev(prev), .en_q(en_q),
    .sense_q(sense_q), .pol_q(pol_q), .eoi_clr(eoi_clr),
    .edge_evt(edge_evt), .edge_lat(edge_lat), .status(status)
  );

  assign pin_out = dout_q;
  assign pin_oe  = dir_q;
  assign irq_out = |status;
endmodule

// File: rtl/pin_bank_chk.sv
module pin_bank_chk
  import pin_bank_pkg::*;
#(
  parameter int NPINS = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [BUS_W-1:0]  bus_wdata,
  input logic [NPINS-1:0]  pin_oe,
  input logic              irq_out,
  input logic [NPINS-1:0]  en_q,
  input logic [NPINS-1:0]  edge_evt,
  input logic [NPINS-1:0]  eoi_clr,
  input logic [NPINS-1:0]  edge_lat
);
  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pin_oe == '0 && !irq_out));

  a_r2_dir_drives_oe: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_DIR) |=> pin_oe == $past(bus_wdata[NPINS-1:0]));

  a_r5_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_lat & ~eoi_clr) != '0 |=> (($past(edge_lat & ~eoi_clr)) & ~edge_lat) == '0);

  a_r6_eoi_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_clr & ~edge_evt) != '0 |=> (edge_lat & $past(eoi_clr & ~edge_evt)) == '0);

  a_r10_edge_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_evt & en_q) != '0 |=> (edge_lat & $past(edge_evt & en_q)) == $past(edge_evt & en_q));

  a_r9_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> en_q != '0);
endmodule

bind pin_bank_irq pin_bank_chk #(.NPINS(NPINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .pin_oe(pin_oe), .irq_out(irq_out), .en_q(en_q),
  .edge_evt(edge_evt), .eoi_clr(eoi_clr), .edge_lat(edge_lat)
);

// File: tb/pin_bank_irq_test.sv
module pin_bank_irq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pin_in = '0;
  logic [31:0] pin_out, pin_oe;
  logic        irq_out;
  int checks = 0;
  int errors = 0;

  pin_bank_irq uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq_out(irq_out)
  );

  always #10 clk = ~clk;

  // {direction, output data, pin levels}
  localparam logic [95:0] VEC [0:5] = '{
    {32'h0000_0000, 32'h0000_0000, 32'hA5A5_5A5A},
    {32'hFFFF_FFFF, 32'h1234_5678, 32'h0000_0000},
    {32'h0000_FFFF, 32'hDEAD_BEEF, 32'hFFFF_FFFF},
    {32'h8000_0001, 32'h8000_0000, 32'h0F0F_F0F0},
    {32'h5555_5555, 32'hAAAA_AAAA, 32'h0000_0001},
    {32'hFFFF_0000, 32'h0000_0000, 32'h8000_0000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic do_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic set_pins(input logic [31:0] v);
    @(negedge clk);
    pin_in = v;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 pin_oe", pin_oe, 32'h0);
    check("R1 pin_out", pin_out, 32'h0);
    check("R1 irq", {31'b0, irq_out}, 32'h0);
    do_rd(8'h30, r); check("R1 enable reg", r, 32'h0);
    do_rd(8'h40, r); check("R1 status", r, 32'h0);

    // R2 R3 R11 vector table
    for (int k = 0; k < 6; k++) begin
      logic [31:0] vdir, vdat, vpin;
      {vdir, vdat, vpin} = VEC[k];
      do_wr(8'h04, vdir);
      do_wr(8'h00, vdat);
      set_pins(vpin);
      check("R2 pin_oe", pin_oe, vdir);
      check("R2 pin_out", pin_out, vdat);
      do_rd(8'h50, r); check("R3 level readback", r, vpin);
      do_rd(8'h04, r); check("R11 dir readback", r, vdir);
      do_rd(8'h00, r); check("R11 data readback", r, vdat);
    end

    // R3 level register ignores writes; R11 unmapped reads zero
    do_wr(8'h50, 32'h1234_0000);
    do_rd(8'h50, r); check("R3 write ignored", r, 32'h8000_0000);
    do_rd(8'h20, r); check("R11 unmapped", r, 32'h0);

    // R4 level sensing: bits 0,2 active high; bits 1,3 active low
    do_wr(8'h04, 32'h0);
    set_pins(32'h0);
    do_wr(8'h38, 32'h0);
    do_wr(8'h3C, 32'h5);
    do_wr(8'h30, 32'hF);
    do_rd(8'h3C, r); check("R11 pol readback", r, 32'h5);
    do_rd(8'h40, r); check("R4 low-active pending", r, 32'hA);
    check("R9 irq with status", {31'b0, irq_out}, 32'h1);
    set_pins(32'hF);
    do_rd(8'h40, r); check("R4 high-active pending", r, 32'h5);
    do_wr(8'h4C, 32'hF);
    do_rd(8'h40, r); check("R7 eoi on level pins", r, 32'h5);
    set_pins(32'h0);
    do_rd(8'h40, r); check("R4 level follows input", r, 32'hA);

    // R8 disable masks everything
    do_wr(8'h30, 32'h0);
    do_rd(8'h40, r); check("R8 disabled status", r, 32'h0);
    check("R9 irq low", {31'b0, irq_out}, 32'h0);

    // R5 R6 edge sensing: bit0 rising, bit1 falling
    set_pins(32'h2);
    do_wr(8'h38, 32'h3);
    do_wr(8'h3C, 32'h1);
    do_wr(8'h30, 32'h3);
    do_rd(8'h40, r); check("R5 no edge yet", r, 32'h0);
    set_pins(32'h3);
    do_rd(8'h40, r); check("R5 rising latched", r, 32'h1);
    set_pins(32'h2);
    do_rd(8'h40, r); check("R5 stays after return", r, 32'h1);
    set_pins(32'h0);
    do_rd(8'h40, r); check("R5 falling latched", r, 32'h3);
    do_wr(8'h4C, 32'h0);
    do_rd(8'h40, r); check("R6 zero write no effect", r, 32'h3);
    do_wr(8'h4C, 32'h1);
    do_rd(8'h40, r); check("R6 clear bit0 only", r, 32'h2);
    do_rd(8'h4C, r); check("R6 eoi reads zero", r, 32'h0);
    do_wr(8'h4C, 32'h2);
    do_rd(8'h40, r); check("R6 all cleared", r, 32'h0);
    check("R9 irq cleared", {31'b0, irq_out}, 32'h0);

    // R8 edge while disabled is not latched
    do_wr(8'h30, 32'h0);
    set_pins(32'h1);
    do_wr(8'h30, 32'h3);
    do_rd(8'h40, r); check("R8 edge while disabled", r, 32'h0);

    // R10 edge coincides with clearing write
    set_pins(32'h0);
    set_pins(32'h1);
    do_rd(8'h40, r); check("R10 setup pending", r, 32'h1);
    set_pins(32'h0);
    @(negedge clk);
    pin_in = 32'h1;
    @(posedge clk);
    @(posedge clk);
    do_wr(8'h4C, 32'h1);
    do_rd(8'h40, r); check("R10 edge wins over eoi", r, 32'h1);
    do_wr(8'h4C, 32'h1);
    do_rd(8'h40, r); check("R6 plain clear after R10", r, 32'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule